// File: doc/BRIEF.md
# Coprocessor Context Save/Restore Sequencer

This block sits on the main-processor side of a coprocessor link. It carries out the two privileged context instructions. A save instruction pulls the coprocessor's internal state out into memory. A restore instruction pushes a previously saved state back into the coprocessor. A start strobe latches the instruction's operation word together with the supervisor flag and a memory address that has already been resolved. From that point the sequencer drives every access on its own. It uses a single-cycle register port toward the coprocessor's interface registers and a single-cycle word port toward memory.

A context image in memory begins with a 16-bit format word, held in the low half of a 32-bit memory word. The context words follow it at rising addresses. The format word's upper byte is a status code and its lower byte is the image length in bytes. The sequencer polls the coprocessor while the coprocessor reports that it is not ready. It rejects malformed format words, and on a rejected word it first cancels the coprocessor operation and then signals the error. It reports each outcome with a one-cycle pulse.

Top module: `cp_ctx_seq`

## Requirements
- R1: An operation word is accepted only if bits 15:12 are 4'hF and bits 11:9 equal the CP_ID parameter. Bits 8:6 then select the operation: 3'b100 selects save and 3'b101 selects restore. Any other word strobed in with start_i causes no access and no pulse.
- R2: If super_i is low when an accepted word is strobed, priv_err_o pulses for one cycle in the cycle after the strobe, and no coprocessor register access takes place.
- R3: A save begins, in the cycle after the strobe, by reading the save register. Register selects are 0 = control, 1 = save, 2 = restore and 3 = operand. The format code is bits 15:8 of the data read and the byte length is bits 7:0.
- R4: The code 8'h02 means not ready, whatever the length. The same register is read again on each following cycle, up to POLL_MAX reads in total. If the last of those reads is still not ready, proto_err_o pulses in the next cycle.
- R5: A format word is invalid if its code is 8'h00 or 8'h01, or if its length has bit 1 or bit 0 set. In that case the sequencer writes 32'h0000_0001 to the control register, and in the following cycle fmt_err_o pulses.
- R6: When a save format word is valid, the sequencer writes {16'h0, format word} to memory at ea_i. It then moves length/4 words, one per cycle, from operand register reads to memory writes at ea_i+4, ea_i+8 and onward.
- R7: A restore first reads memory at ea_i and, in the same cycle, writes the low 16 bits of that word to the restore register. In the next cycle it reads the restore register, and that status is handled under R4 and R5.
- R8: After a valid restore status, length/4 words move, one per cycle, from memory reads at ea_i+4, ea_i+8 and onward into writes of the operand register.
- R9: done_o pulses for one cycle, in the cycle after the last context word is moved. If the length is zero, it pulses right after the format step.
- R10: A start strobe that arrives while an operation is in progress is ignored.
- R11: After reset, and between operations, every output is low. At most one of the four result pulses is high in any cycle, and memory is never read and written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe that latches the operation |
| opcode_i | input | 16 | Instruction operation word |
| super_i | input | 1 | Supervisor privilege flag |
| ea_i | input | ADDR_W | Resolved address of the context image |
| cir_rd_o | output | 1 | Coprocessor register read |
| cir_wr_o | output | 1 | Coprocessor register write |
| cir_sel_o | output | 2 | Register select (0 control, 1 save, 2 restore, 3 operand) |
| cir_wdata_o | output | 32 | Register write data |
| cir_rdata_i | input | 32 | Register read data, valid in the same cycle |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid in the same cycle |
| done_o | output | 1 | Operation completed |
| priv_err_o | output | 1 | Privilege violation request |
| fmt_err_o | output | 1 | Format error request |
| proto_err_o | output | 1 | Poll limit exceeded |

## Verification
The bench builds the block with POLL_MAX = 3 and CP_ID = 5. The short poll limit means the not-ready exhaustion path is reached after only three reads, and a run of two not-ready codes ahead of a valid one can be checked against the exact limit. A non-zero identifier lets a word that differs only in bits 11:9 be shown to be ignored. The bench can also push a second strobe into the middle of a save and see the access sequence continue unchanged.

// File: rtl/cp_ctx_pkg.sv
package cp_ctx_pkg;

    localparam int DATA_W          = 32;
    localparam int FMT_W           = 16;
    localparam int WORD_CNT_W      = 6;
    localparam int BYTES_PER_WORD  = 4;

    localparam logic [7:0]        CODE_NOT_READY = 8'h02;
    localparam logic [DATA_W-1:0] ABORT_MASK     = 32'h0000_0001;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_SAVE    = 2'd1,
        SEL_RESTORE = 2'd2,
        SEL_OPERAND = 2'd3
    } cir_sel_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SAVE,
        OP_RESTORE
    } op_kind_e;

    typedef enum logic [1:0] {
        FMT_VALID,
        FMT_NOT_READY,
        FMT_INVALID
    } fmt_class_e;

    typedef struct packed {
        fmt_class_e            cls;
        logic [WORD_CNT_W-1:0] words;
        logic [FMT_W-1:0]      word;
    } fmt_info_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRIV,
        ST_SPOLL,
        ST_SFMT,
        ST_RFETCH,
        ST_RPOLL,
        ST_XFER,
        ST_ABORT,
        ST_FERR,
        ST_PERR,
        ST_DONE
    } state_e;

    function automatic fmt_class_e classify(input logic [FMT_W-1:0] w);
        if (w[15:8] == CODE_NOT_READY)
            return FMT_NOT_READY;
        if (w[15:8] < 8'h02 || w[1:0] != 2'b00)
            return FMT_INVALID;
        return FMT_VALID;
    endfunction

endpackage

// File: rtl/cp_ctx_decode.sv
module cp_ctx_decode
    import cp_ctx_pkg::*;
#(
    parameter logic [2:0] CP_ID = 3'd1
) (
    input  logic [15:0] opcode_i,
    output op_kind_e    kind_o
);

    logic line_hit;

    assign line_hit = (opcode_i[15:12] == 4'hF) && (opcode_i[11:9] == CP_ID);

    always_comb begin
        kind_o = OP_NONE;
        if (line_hit) begin
            unique case (opcode_i[8:6])
                3'b100:  kind_o = OP_SAVE;
                3'b101:  kind_o = OP_RESTORE;
                default: kind_o = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cp_ctx_fmtchk.sv
module cp_ctx_fmtchk
    import cp_ctx_pkg::*;
(
    input  logic [DATA_W-1:0] rdata_i,
    output fmt_info_t         info_o
);

    always_comb begin
        info_o.word  = rdata_i[FMT_W-1:0];
        info_o.cls   = classify(rdata_i[FMT_W-1:0]);
        info_o.words = rdata_i[7:2];
    end

endmodule

// File: rtl/cp_ctx_walker.sv
module cp_ctx_walker
    import cp_ctx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic                  step_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [WORD_CNT_W-1:0] words_i,
    output logic [ADDR_W-1:0]     ptr_o,
    output logic                  none_o,
    output logic                  last_o
);

    logic [WORD_CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            ptr_o  <= base_i + ADDR_W'(BYTES_PER_WORD);
            left_q <= words_i;
        end else if (step_i) begin
            ptr_o  <= ptr_o + ADDR_W'(BYTES_PER_WORD);
            left_q <= left_q - 1'b1;
        end
    end

    assign none_o = (left_q == '0);
    assign last_o = (left_q == WORD_CNT_W'(1));

    // R8
    step_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (left_q != '0));

endmodule

// File: rtl/cp_ctx_seq.sv
module cp_ctx_seq
    import cp_ctx_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         POLL_MAX = 4,
    parameter logic [2:0] CP_ID    = 3'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [15:0]       opcode_i,
    input  logic              super_i,
    input  logic [ADDR_W-1:0] ea_i,
    output logic              cir_rd_o,
    output logic              cir_wr_o,
    output logic [1:0]        cir_sel_o,
    output logic [31:0]       cir_wdata_o,
    input  logic [31:0]       cir_rdata_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    output logic              done_o,
    output logic              priv_err_o,
    output logic              fmt_err_o,
    output logic              proto_err_o
);

    localparam int PW = $clog2(POLL_MAX + 1);

    state_e            state;
    op_kind_e          kind, kind_q;
    fmt_info_t         info;
    logic [ADDR_W-1:0] ea_q, ptr;
    logic [FMT_W-1:0]  fmt_q;
    logic [PW-1:0]     polls;
    logic              polling, fmt_ok, w_none, w_last;

    cp_ctx_decode #(.CP_ID(CP_ID)) u_decode (
        .opcode_i (opcode_i),
        .kind_o   (kind)
    );

    cp_ctx_fmtchk u_fmtchk (
        .rdata_i (cir_rdata_i),
        .info_o  (info)
    );

    assign polling = (state == ST_SPOLL) || (state == ST_RPOLL);
    assign fmt_ok  = polling && (info.cls == FMT_VALID);

    cp_ctx_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk     (clk),
        .rst     (rst),
        .load_i  (fmt_ok),
        .step_i  (state == ST_XFER),
        .base_i  (ea_q),
        .words_i (info.words),
        .ptr_o   (ptr),
        .none_o  (w_none),
        .last_o  (w_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind_q <= OP_NONE;
            ea_q   <= '0;
            fmt_q  <= '0;
            polls  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i && kind != OP_NONE) begin
                        kind_q <= kind;
                        ea_q   <= ea_i;
                        polls  <= '0;
                        if (!super_i)            state <= ST_PRIV;
                        else if (kind == OP_SAVE) state <= ST_SPOLL;
                        else                     state <= ST_RFETCH;
                    end
                end
                ST_SPOLL, ST_RPOLL: begin
                    unique case (info.cls)
                        FMT_NOT_READY: begin
                            if (polls == PW'(POLL_MAX - 1)) state <= ST_PERR;
                            else                            polls <= polls + 1'b1;
                        end
                        FMT_INVALID: state <= ST_ABORT;
                        default: begin
                            fmt_q <= info.word;
                            if (kind_q == OP_SAVE)      state <= ST_SFMT;
                            else if (info.words == '0)  state <= ST_DONE;
                            else                        state <= ST_XFER;
                        end
                    endcase
                end
                ST_SFMT:   state <= w_none ? ST_DONE : ST_XFER;
                ST_RFETCH: state <= ST_RPOLL;
                ST_XFER:   if (w_last) state <= ST_DONE;
                ST_ABORT:  state <= ST_FERR;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cir_rd_o    = 1'b0;
        cir_wr_o    = 1'b0;
        cir_sel_o   = SEL_CTRL;
        cir_wdata_o = '0;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        done_o      = 1'b0;
        priv_err_o  = 1'b0;
        fmt_err_o   = 1'b0;
        proto_err_o = 1'b0;
        unique case (state)
            ST_SPOLL: begin
                cir_rd_o  = 1'b1;
                cir_sel_o = SEL_SAVE;
            end
            ST_RPOLL: begin
                cir_rd_o  = 1'b1;
                cir_sel_o = SEL_RESTORE;
            end
            ST_SFMT: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = ea_q;
                mem_wdata_o = {16'h0, fmt_q};
            end
            ST_RFETCH: begin
                mem_rd_o    = 1'b1;
                mem_addr_o  = ea_q;
                cir_wr_o    = 1'b1;
                cir_sel_o   = SEL_RESTORE;
                cir_wdata_o = {16'h0, mem_rdata_i[FMT_W-1:0]};
            end
            ST_XFER: begin
                mem_addr_o = ptr;
                cir_sel_o  = SEL_OPERAND;
                if (kind_q == OP_SAVE) begin
                    cir_rd_o    = 1'b1;
                    mem_wr_o    = 1'b1;
                    mem_wdata_o = cir_rdata_i;
                end else begin
                    mem_rd_o    = 1'b1;
                    cir_wr_o    = 1'b1;
                    cir_wdata_o = mem_rdata_i;
                end
            end
            ST_ABORT: begin
                cir_wr_o    = 1'b1;
                cir_sel_o   = SEL_CTRL;
                cir_wdata_o = ABORT_MASK;
            end
            ST_PRIV: priv_err_o  = 1'b1;
            ST_FERR: fmt_err_o   = 1'b1;
            ST_PERR: proto_err_o = 1'b1;
            ST_DONE: done_o      = 1'b1;
            default: ;
        endcase
    end

    // R2
    priv_no_cir_chk: assert property (@(posedge clk) disable iff (rst)
        priv_err_o |-> (!cir_rd_o && !cir_wr_o && $past(!cir_rd_o && !cir_wr_o)));

    // R5
    abort_before_ferr_chk: assert property (@(posedge clk) disable iff (rst)
        fmt_err_o |-> $past(cir_wr_o && cir_sel_o == SEL_CTRL && cir_wdata_o == ABORT_MASK));

    // R4
    proto_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |-> $past(cir_rd_o));

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, priv_err_o, fmt_err_o, proto_err_o}));

    // R11
    mem_port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && $past(state) == ST_XFER)
            |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(BYTES_PER_WORD)));

endmodule

// File: tb/cp_ctx_seq_tb.sv
`timescale 1ns/1ps
module cp_ctx_seq_tb;

    localparam int         POLL_MAX = 3;
    localparam logic [2:0] CPID     = 3'd5;

    typedef struct packed {
        logic        crd;
        logic        cwr;
        logic [1:0]  sel;
        logic [31:0] cwd;
        logic        mrd;
        logic        mwr;
        logic [31:0] maddr;
        logic [31:0] mwd;
        logic [3:0]  pulse;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] opcode_i = '0;
    logic        super_i = 1'b0;
    logic [31:0] ea_i = '0;
    logic        cir_rd_o, cir_wr_o, mem_rd_o, mem_wr_o;
    logic [1:0]  cir_sel_o;
    logic [31:0] cir_wdata_o, cir_rdata_i, mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        done_o, priv_err_o, fmt_err_o, proto_err_o;

    logic [31:0] mem [0:63];
    logic [31:0] resp_arr [0:63];
    int          resp_idx, resp_wr, opnd_cnt;
    int          total = 0, fails = 0;
    ev_t         exp_q [$];

    always #10 clk = ~clk;

    cp_ctx_seq #(.ADDR_W(32), .POLL_MAX(POLL_MAX), .CP_ID(CPID)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
        .super_i(super_i), .ea_i(ea_i),
        .cir_rd_o(cir_rd_o), .cir_wr_o(cir_wr_o), .cir_sel_o(cir_sel_o),
        .cir_wdata_o(cir_wdata_o), .cir_rdata_i(cir_rdata_i),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .priv_err_o(priv_err_o), .fmt_err_o(fmt_err_o),
        .proto_err_o(proto_err_o)
    );

    // coprocessor and memory models
    assign cir_rdata_i = (cir_sel_o == 2'd3) ? (32'hA000_0000 + 32'(opnd_cnt))
                                             : resp_arr[resp_idx[5:0]];
    assign mem_rdata_i = mem[mem_addr_o[7:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hC000_0000 + 32'(i);
            resp_idx <= 0;
            opnd_cnt <= 0;
        end else begin
            if (cir_rd_o && (cir_sel_o == 2'd1 || cir_sel_o == 2'd2)) resp_idx <= resp_idx + 1;
            if (cir_rd_o && cir_sel_o == 2'd3) opnd_cnt <= opnd_cnt + 1;
            if (mem_wr_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
        end
    end

    function automatic ev_t mk(logic crd, logic cwr, logic [1:0] sel, logic [31:0] cwd,
                               logic mrd, logic mwr, logic [31:0] maddr, logic [31:0] mwd,
                               logic [3:0] pulse);
        ev_t e;
        e.crd = crd; e.cwr = cwr; e.sel = sel; e.cwd = cwd;
        e.mrd = mrd; e.mwr = mwr; e.maddr = maddr; e.mwd = mwd; e.pulse = pulse;
        return e;
    endfunction

    function automatic ev_t actual();
        return mk(cir_rd_o, cir_wr_o, cir_sel_o, cir_wdata_o, mem_rd_o, mem_wr_o,
                  mem_addr_o, mem_wdata_o, {done_o, priv_err_o, fmt_err_o, proto_err_o});
    endfunction

    function automatic logic [15:0] opw(logic [3:0] top, logic [2:0] id, logic [2:0] kind);
        return {top, id, kind, 6'h10};
    endfunction

    task automatic check(input bit ok, input string tag, input ev_t a, input ev_t e);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic push_resp(input logic [31:0] w);
        resp_arr[resp_wr[5:0]] = w;
        resp_wr++;
    endtask

    // behavioural reference: builds the expected per-cycle port trace
    task automatic model(input logic [15:0] op, input logic sup, input logic [31:0] ea);
        ev_t idle;
        bit  is_save, is_rest;
        int  k, polls, nw;
        logic [31:0] w;
        idle = mk(0, 0, 0, 0, 0, 0, 0, 0, 4'b0000);
        exp_q.delete();
        is_save = (op[15:12] == 4'hF) && (op[11:9] == CPID) && (op[8:6] == 3'b100);
        is_rest = (op[15:12] == 4'hF) && (op[11:9] == CPID) && (op[8:6] == 3'b101);
        if (!is_save && !is_rest) begin
            exp_q.push_back(idle);
            exp_q.push_back(idle);
            return;
        end
        if (!sup) begin
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 4'b0100));
            exp_q.push_back(idle);
            return;
        end
        if (is_rest)
            exp_q.push_back(mk(0, 1, 2'd2, {16'h0, mem[ea[7:2]][15:0]}, 1, 0, ea, 0, 4'b0000));
        k = resp_idx;
        polls = 0;
        forever begin
            exp_q.push_back(mk(1, 0, is_save ? 2'd1 : 2'd2, 0, 0, 0, 0, 0, 4'b0000));
            w = resp_arr[k[5:0]];
            k++;
            polls++;
            if (w[15:8] == 8'h02) begin
                if (polls == POLL_MAX) begin
                    exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 4'b0001));
                    break;
                end
            end else if (w[15:8] < 8'h02 || w[1:0] != 2'b00) begin
                exp_q.push_back(mk(0, 1, 2'd0, 32'h1, 0, 0, 0, 0, 4'b0000));
                exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 4'b0010));
                break;
            end else begin
                nw = int'(w[7:0]) / 4;
                if (is_save)
                    exp_q.push_back(mk(0, 0, 0, 0, 0, 1, ea, {16'h0, w[15:0]}, 4'b0000));
                for (int j = 0; j < nw; j++) begin
                    logic [31:0] a;
                    a = ea + 32'(4 * (j + 1));
                    if (is_save)
                        exp_q.push_back(mk(1, 0, 2'd3, 0, 0, 1, a,
                                           32'hA000_0000 + 32'(opnd_cnt + j), 4'b0000));
                    else
                        exp_q.push_back(mk(0, 1, 2'd3, mem[a[7:2]], 1, 0, a, 0, 4'b0000));
                end
                exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 4'b1000));
                break;
            end
        end
        exp_q.push_back(idle);
    endtask

    task automatic run(input logic [15:0] op, input logic sup, input logic [31:0] ea,
                       input string tag, input int restart_at);
        ev_t e, a;
        model(op, sup, ea);
        start_i  = 1'b1;
        opcode_i = op;
        super_i  = sup;
        ea_i     = ea;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; exp_q.size() > 0; i++) begin
            e = exp_q.pop_front();
            a = actual();
            check(a == e, tag, a, e);
            if (i == restart_at) begin
                start_i  = 1'b1;                         // R10: ignored while busy
                opcode_i = opw(4'hF, CPID, 3'b101);
                super_i  = 1'b1;
                ea_i     = 32'h0;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] op_sv, op_rs;
        op_sv = opw(4'hF, CPID, 3'b100);
        op_rs = opw(4'hF, CPID, 3'b101);
        resp_wr = 0;
        for (int i = 0; i < 64; i++) resp_arr[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(actual() == mk(0, 0, 0, 0, 0, 0, 0, 0, 4'b0000), "R11 reset",
              actual(), mk(0, 0, 0, 0, 0, 0, 0, 0, 4'b0000));

        push_resp(32'h0000_2008);
        run(op_sv, 1'b1, 32'h40, "R3 R6 R9 R10 save two words, restart ignored", 1);
        push_resp(32'h0000_0200); push_resp(32'h0000_0200); push_resp(32'h0000_2104);
        run(op_sv, 1'b1, 32'h100, "R4 save after two not-ready", -1);
        push_resp(32'h0000_0200); push_resp(32'h0000_0200); push_resp(32'h0000_0200);
        run(op_sv, 1'b1, 32'h40, "R4 poll limit", -1);
        push_resp(32'h0000_0108);
        run(op_sv, 1'b1, 32'h40, "R5 invalid code", -1);
        push_resp(32'h0000_2006);
        run(op_sv, 1'b1, 32'h40, "R5 unaligned length", -1);
        push_resp(32'h0000_2200);
        run(op_sv, 1'b1, 32'h20, "R9 zero-length save", -1);
        push_resp(32'h0000_3008);
        run(op_rs, 1'b1, 32'h80, "R7 R8 restore two words", -1);
        push_resp(32'h0000_3000);
        run(op_rs, 1'b1, 32'h90, "R9 zero-length restore", -1);
        push_resp(32'h0000_0204); push_resp(32'h0000_0004);
        run(op_rs, 1'b1, 32'h80, "R5 R7 restore invalid after not-ready", -1);
        run(op_sv, 1'b0, 32'h40, "R2 user save", -1);
        run(op_rs, 1'b0, 32'h80, "R2 user restore", -1);
        run(opw(4'hF, CPID, 3'b110), 1'b1, 32'h40, "R1 other op field", -1);
        run(opw(4'hF, 3'd2, 3'b100), 1'b1, 32'h40, "R1 other coprocessor id", -1);
        run(opw(4'hE, CPID, 3'b100), 1'b1, 32'h40, "R1 non-coprocessor line", -1);
        push_resp(32'h0000_2304);
        run(op_sv, 1'b1, 32'hC0, "R3 R6 save after ignored words", -1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule